// File: doc/BRIEF.md
# Two-Dimensional Work-Grid Address Walker

This block sequences a rectangular grid of work items for a vector execution stage. Software programs three base addresses, the grid width and height, a row stride and an element shift through a small write-only register port. It then launches a run by writing a fixed 32-bit key to the launch register. The walker visits every item once and gives the execution stage three byte addresses for each one. Two are one-dimensional load addresses: one is indexed by the column and one by the row. The third is a row-major store address. Items are presented on a valid/ready stream together with their coordinates.

The grid settings are copied into a private snapshot at launch, so software may prepare the next run while the current one is draining. When the final item has been taken, a one-cycle completion pulse tells the sequencer that the grid is finished. With the reset defaults, each element is a 16-byte four-lane vector (shift 4) in a 16 by 16 grid with a row stride of 16.

Top module: `grid_addr_gen`

## Requirements
- R1: After reset `item_valid` and `run_done` are low. The registers reset to: store base 0, column-load base 0, row-load base 0, width 16, height 16, stride 16, shift 4.
- R2: The register port uses these `cfg_sel` values: 0 store base, 1 column-load base, 2 row-load base, 3 width, 4 height, 5 row stride, 6 shift, 7 launch. A launch write with data 0xBADABEEB starts a run. `item_valid` rises in the cycle after that write, with the item at column 0 and row 0.
- R3: A launch write with any other data value starts nothing.
- R4: Items are issued with the column varying fastest and then the row. Every (x, y) with x below width and y below height is issued exactly once, and `item_valid` stays high until the last item has been taken.
- R5: `item_haddr` equals the column-load base plus (x shifted left by shift), modulo 2^32.
- R6: `item_vaddr` equals the row-load base plus (y shifted left by shift), modulo 2^32.
- R7: `item_waddr` equals the store base plus ((y times stride plus x) shifted left by shift), modulo 2^32.
- R8: While `item_valid` is high and `item_ready` is low, the coordinates and all three addresses hold their values in the next cycle.
- R9: `run_done` is high for exactly one cycle. That cycle directly follows the cycle in which the last item was accepted.
- R10: A launch write that arrives while a run is in progress is ignored. It neither restarts nor extends the run.
- R11: Register writes made during a run do not change the addresses or the item count of that run.
- R12: A launch write while width or height is 0 starts no run and produces no `run_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| item_ready | input | 1 | Downstream accepts the current item |
| item_valid | output | 1 | Item stream valid |
| item_x | output | 16 | Column of the current item |
| item_y | output | 16 | Row of the current item |
| item_haddr | output | 32 | Column-indexed load address |
| item_vaddr | output | 32 | Row-indexed load address |
| item_waddr | output | 32 | Row-major store address |
| run_done | output | 1 | One-cycle completion pulse |

## Verification
A counter that wraps or advances at the wrong time shows up in the very next accepted item, as a coordinate pair or store address that is out of order. A corrupted snapshot changes the load or store addresses from the first item of the run. A walker that mishandles the last item or a stray launch shows up within one cycle: `run_done` arrives early or late, or `item_valid` reappears after completion. Random backpressure exposes any output that drifts during a stall on the cycle after the stall begins.

// File: rtl/gag_pkg.sv
// Package: shared constants for the grid address walker.
// Assumes the register port is 3 bits wide and the data path is 32 bits.
package gag_pkg;
    localparam logic [31:0] GAG_LAUNCH_KEY = 32'hBADA_BEEB;

    typedef enum logic [2:0] {
        SEL_WBASE  = 3'd0,
        SEL_HBASE  = 3'd1,
        SEL_VBASE  = 3'd2,
        SEL_WIDTH  = 3'd3,
        SEL_HEIGHT = 3'd4,
        SEL_STRIDE = 3'd5,
        SEL_SHIFT  = 3'd6,
        SEL_LAUNCH = 3'd7
    } gag_sel_e;
endpackage

// File: rtl/gag_cfg_regs.sv
// Register file with launch detection and a run snapshot.
// Live registers accept writes at any time. The snapshot is loaded only
// when a valid launch is accepted while the walker is idle.
// Assumes AW is at least CW and SW.
module gag_cfg_regs #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    sel,
    input  logic [AW-1:0] wdata,
    input  logic          busy,
    output logic          start,
    output logic [AW-1:0] snap_wbase,
    output logic [AW-1:0] snap_hbase,
    output logic [AW-1:0] snap_vbase,
    output logic [CW-1:0] snap_width,
    output logic [CW-1:0] snap_height,
    output logic [CW-1:0] snap_stride,
    output logic [SW-1:0] snap_shift
);
    import gag_pkg::*;

    logic [AW-1:0] live_wbase, live_hbase, live_vbase;
    logic [CW-1:0] live_width, live_height, live_stride;
    logic [SW-1:0] live_shift;

    // Launch accepted: key matches, walker idle, grid not empty.
    always_comb begin
        start = we && (sel == SEL_LAUNCH) && (wdata == GAG_LAUNCH_KEY[AW-1:0])
                && !busy && (live_width != '0) && (live_height != '0);
    end

    // Live register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_wbase  <= '0;
            live_hbase  <= '0;
            live_vbase  <= '0;
            live_width  <= CW'(16);
            live_height <= CW'(16);
            live_stride <= CW'(16);
            live_shift  <= SW'(4);
        end else if (we) begin
            case (sel)
                SEL_WBASE:  live_wbase  <= wdata;
                SEL_HBASE:  live_hbase  <= wdata;
                SEL_VBASE:  live_vbase  <= wdata;
                SEL_WIDTH:  live_width  <= wdata[CW-1:0];
                SEL_HEIGHT: live_height <= wdata[CW-1:0];
                SEL_STRIDE: live_stride <= wdata[CW-1:0];
                SEL_SHIFT:  live_shift  <= wdata[SW-1:0];
                default:    ;
            endcase
        end
    end

    // Snapshot copy on an accepted launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_wbase  <= '0;
            snap_hbase  <= '0;
            snap_vbase  <= '0;
            snap_width  <= '0;
            snap_height <= '0;
            snap_stride <= '0;
            snap_shift  <= '0;
        end else if (start) begin
            snap_wbase  <= live_wbase;
            snap_hbase  <= live_hbase;
            snap_vbase  <= live_vbase;
            snap_width  <= live_width;
            snap_height <= live_height;
            snap_stride <= live_stride;
            snap_shift  <= live_shift;
        end
    end

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> $stable(snap_width) && $stable(snap_stride) && $stable(snap_wbase)); // R11
endmodule

// File: rtl/gag_walker.sv
// Grid walker: steps the column first and then the row, under valid/ready.
// Assumes start is only raised while the walker is idle and the sizes are non-zero.
module gag_walker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          ready,
    output logic          valid,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output logic          done
);
    logic row_end, last_item, take;

    // Position decode for the current item.
    always_comb begin
        row_end   = (x == width - CW'(1));
        last_item = row_end && (y == height - CW'(1));
        take      = valid && ready;
    end

    // Counter and handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            x     <= '0;
            y     <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                valid <= 1'b1;
                x     <= '0;
                y     <= '0;
            end else if (take) begin
                if (last_item) begin
                    valid <= 1'b0;
                    done  <= 1'b1;
                end else if (row_end) begin
                    x <= '0;
                    y <= y + CW'(1);
                end else begin
                    x <= x + CW'(1);
                end
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(x) && $stable(y)); // R8
    AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (x < width) && (y < height)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(valid && ready) && !valid); // R9
endmodule

// File: rtl/gag_addr_calc.sv
// Address arithmetic for one item: two 1-D load addresses and a row-major
// store address. Purely combinational; all sums wrap modulo 2^AW.
module gag_addr_calc #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 5
) (
    input  logic [AW-1:0] wbase,
    input  logic [AW-1:0] hbase,
    input  logic [AW-1:0] vbase,
    input  logic [CW-1:0] stride,
    input  logic [SW-1:0] shift,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic [AW-1:0] haddr,
    output logic [AW-1:0] vaddr,
    output logic [AW-1:0] waddr
);
    localparam int NLOAD = 2;

    logic [AW-1:0] lbase  [NLOAD];
    logic [CW-1:0] lcoord [NLOAD];
    logic [AW-1:0] laddr  [NLOAD];
    logic [AW-1:0] linear;

    assign lbase[0]  = hbase;
    assign lbase[1]  = vbase;
    assign lcoord[0] = x;
    assign lcoord[1] = y;

    // One shifter-adder per one-dimensional load.
    for (genvar i = 0; i < NLOAD; i++) begin : g_load
        always_comb laddr[i] = lbase[i] + (AW'(lcoord[i]) << shift);
    end

    // Row-major element index, then scale to bytes.
    always_comb begin
        linear = AW'(y) * AW'(stride) + AW'(x);
        haddr  = laddr[0];
        vaddr  = laddr[1];
        waddr  = wbase + (linear << shift);
    end
endmodule

// File: rtl/grid_addr_gen.sv
// Top: register port, grid walker and address arithmetic.
// Assumes the downstream stage samples item fields whenever item_valid is high.
module grid_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          item_ready,
    output logic          item_valid,
    output logic [CW-1:0] item_x,
    output logic [CW-1:0] item_y,
    output logic [AW-1:0] item_haddr,
    output logic [AW-1:0] item_vaddr,
    output logic [AW-1:0] item_waddr,
    output logic          run_done
);
    logic          start;
    logic [AW-1:0] s_wbase, s_hbase, s_vbase;
    logic [CW-1:0] s_width, s_height, s_stride;
    logic [SW-1:0] s_shift;

    gag_cfg_regs #(.AW(AW), .CW(CW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .busy(item_valid), .start(start),
        .snap_wbase(s_wbase), .snap_hbase(s_hbase), .snap_vbase(s_vbase),
        .snap_width(s_width), .snap_height(s_height), .snap_stride(s_stride),
        .snap_shift(s_shift)
    );

    gag_walker #(.CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .width(s_width), .height(s_height),
        .ready(item_ready), .valid(item_valid), .x(item_x), .y(item_y), .done(run_done)
    );

    gag_addr_calc #(.AW(AW), .CW(CW), .SW(SW)) u_addr (
        .wbase(s_wbase), .hbase(s_hbase), .vbase(s_vbase), .stride(s_stride),
        .shift(s_shift), .x(item_x), .y(item_y),
        .haddr(item_haddr), .vaddr(item_vaddr), .waddr(item_waddr)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        item_valid && !item_ready |=> $stable(item_haddr) && $stable(item_vaddr) && $stable(item_waddr)); // R8
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        item_valid && !(item_ready && $past(item_valid)) && cfg_we |=> !(item_x == '0 && item_y == '0 && $past(item_x != '0 || item_y != '0) && !$past(item_ready))); // R10
endmodule

// File: tb/grid_addr_gen_test.sv
module grid_addr_gen_test;
    localparam logic [31:0] KEY = 32'hBADA_BEEB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        item_ready = 1'b0;
    logic        item_valid;
    logic [15:0] item_x, item_y;
    logic [31:0] item_haddr, item_vaddr, item_waddr;
    logic        run_done;

    int nchk = 0;
    int nerr = 0;
    bit ended = 0;

    grid_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .item_ready(item_ready), .item_valid(item_valid), .item_x(item_x), .item_y(item_y),
        .item_haddr(item_haddr), .item_vaddr(item_vaddr), .item_waddr(item_waddr),
        .run_done(run_done)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] f_load(input logic [31:0] base, input int c, input int sh);
        return base + (32'(c) << sh);
    endfunction

    function automatic logic [31:0] f_store(input logic [31:0] base, input int x, input int y,
                                            input int stride, input int sh);
        logic [31:0] lin;
        lin = 32'(y) * 32'(stride) + 32'(x);
        return base + (lin << sh);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic configure(input logic [31:0] bw, bh, bv, input int sx, sy, st, sh);
        wr(3'd0, bw); wr(3'd1, bh); wr(3'd2, bv);
        wr(3'd3, 32'(sx)); wr(3'd4, 32'(sy)); wr(3'd5, 32'(st)); wr(3'd6, 32'(sh));
    endtask

    task automatic run_grid(input logic [31:0] bw, bh, bv, input int sx, sy, st, sh,
                            input int rdy_pct, input bit mutate);
        int ex = 0, ey = 0, cyc = 0;
        bit exp_done = 0, stall = 0, fin = 0, acc;
        logic [31:0] ph = '0, pv = '0, pw = '0;
        logic [15:0] px = '0, py = '0;
        wr(3'd7, KEY);
        chk("R2 valid after launch", 32'(item_valid), 1);
        chk("R2 first x", 32'(item_x), 0);
        chk("R2 first y", 32'(item_y), 0);
        while (!fin) begin
            cfg_we = 1'b0;
            if (mutate && cyc == 3) begin cfg_we = 1'b1; cfg_sel = 3'd7; cfg_wdata = KEY; end
            if (mutate && cyc == 5) begin cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'd99; end
            if (mutate && cyc == 6) begin cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h7777_0000; end
            chk("R9 done timing", 32'(run_done), 32'(exp_done));
            if (exp_done) begin
                chk("R4 valid low after last", 32'(item_valid), 0);
                fin = 1;
            end else begin
                chk("R4 valid held", 32'(item_valid), 1);
                if (item_valid) begin
                    if (stall) begin
                        chk("R8 stall x", 32'(item_x), 32'(px));
                        chk("R8 stall y", 32'(item_y), 32'(py));
                        chk("R8 stall haddr", item_haddr, ph);
                        chk("R8 stall vaddr", item_vaddr, pv);
                        chk("R8 stall waddr", item_waddr, pw);
                    end
                    chk("R4 order x", 32'(item_x), 32'(ex));
                    chk("R4 order y", 32'(item_y), 32'(ey));
                    chk("R5 haddr", item_haddr, f_load(bh, ex, sh));
                    chk("R6 vaddr", item_vaddr, f_load(bv, ey, sh));
                    chk("R7/R11 waddr", item_waddr, f_store(bw, ex, ey, st, sh));
                end
                item_ready = (($urandom % 100) < rdy_pct);
                acc = item_valid && item_ready;
                stall = item_valid && !item_ready;
                px = item_x; py = item_y; ph = item_haddr; pv = item_vaddr; pw = item_waddr;
                if (acc) begin
                    if (ex == sx - 1 && ey == sy - 1) exp_done = 1;
                    else if (ex == sx - 1) begin ex = 0; ey++; end
                    else ex++;
                end
                @(negedge clk);
                cyc++;
                if (cyc > 20000) begin
                    chk("R4 run completes", 0, 1);
                    fin = 1;
                end
            end
        end
        cfg_we = 1'b0;
        item_ready = 1'b0;
        @(negedge clk);
        chk("R9 done single cycle", 32'(run_done), 0);
        chk("R10 no restart", 32'(item_valid), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid at reset", 32'(item_valid), 0);
        chk("R1 done at reset", 32'(run_done), 0);

        // Reset defaults: 16x16, stride 16, shift 4, bases 0.
        run_grid(32'h0, 32'h0, 32'h0, 16, 16, 16, 4, 100, 0);

        // Wrong key: nothing starts.
        wr(3'd7, KEY ^ 32'h1);
        repeat (3) begin
            chk("R3 wrong key no valid", 32'(item_valid), 0);
            chk("R3 wrong key no done", 32'(run_done), 0);
            @(negedge clk);
        end

        // Zero width: launch refused.
        wr(3'd3, 32'd0);
        wr(3'd7, KEY);
        repeat (3) begin
            chk("R12 empty grid no valid", 32'(item_valid), 0);
            chk("R12 empty grid no done", 32'(run_done), 0);
            @(negedge clk);
        end

        // Single item.
        configure(32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 1, 1, 5, 2);
        run_grid(32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 1, 1, 5, 2, 100, 0);

        // Writes and a relaunch during a run.
        configure(32'hA000_0000, 32'hB000_0100, 32'hC000_0200, 4, 4, 9, 3);
        run_grid(32'hA000_0000, 32'hB000_0100, 32'hC000_0200, 4, 4, 9, 3, 60, 1);

        // Random grids with random backpressure, including wrap of the address sum.
        for (int r = 0; r < 20; r++) begin
            logic [31:0] bw, bh, bv;
            int sx, sy, st, sh;
            bw = $urandom; bh = $urandom; bv = $urandom;
            sx = 1 + $urandom % 5; sy = 1 + $urandom % 5;
            st = $urandom % 64; sh = $urandom % 8;
            configure(bw, bh, bv, sx, sy, st, sh);
            run_grid(bw, bh, bv, sx, sy, st, sh, 30 + $urandom % 70, 0);
        end

        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #3ms;
        if (!ended) begin
            ended = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule